// File: doc/BRIEF.md
# Match-Register One-Shot System Timer

This block is a 32-bit system timer with one match register. Software writes a match value, and the block loads a one-shot countdown. The length of the countdown is the distance from the stored counter value to the new match value, and that distance wraps through the top of the 32-bit range when the match value is not larger than the counter. The countdown steps down once on every clock cycle in which `tick_en` is high. The input stands in for a 50 MHz timebase, and tying it high makes the clock itself the timebase.

Reading the counter offset returns the match value minus the remaining countdown, modulo 2^32. When the countdown runs out, the stored counter takes the match value and the countdown stops until the match register is written again. If the interrupt-enable register then holds any nonzero value, a sticky status bit is set. The interrupt output is a registered level that is always equal to that status bit. Software clears the status bit by writing zero to the status offset.

The register port is a plain 32-bit bus and always accepts. A write is taken on every clock edge where `wr_en` is high. There is no back-pressure and no wait state. `rd_data` is combinational from the current register state while `rd_en` is high, and it is zero otherwise. Reads have no side effects.

Top module: `match_timer`

## Requirements
- R1: After reset, the counter (0x10), status (0x14) and interrupt-enable (0x1C) offsets read zero, `irq` is low and no countdown runs.
- R2: A write to offset 0x00 sets the match value M and starts a countdown against the stored counter C. The countdown length is M−C if M>C, and M+(0xFFFFFFFF−C) mod 2^32 otherwise. Writing the match value equal to C therefore reads back C+1 on the counter offset.
- R3: While a countdown runs, the remaining count drops by exactly one on each edge with `tick_en` high, and holds on each edge with `tick_en` low.
- R4: A read of offset 0x10 returns M minus the remaining countdown, modulo 2^32.
- R5: On the edge where a running countdown with remaining value 1 (or 0) sees `tick_en` high, the countdown ends. The stored counter becomes M, counting stops, and offset 0x10 reads M.
- R6: At that expiry, a nonzero interrupt-enable value sets status to 1 and raises `irq` after the same edge. A zero interrupt-enable value leaves status and `irq` unchanged.
- R7: Writing 0 to offset 0x14 clears status and `irq` at that edge. Writing a nonzero value there changes nothing.
- R8: If an expiry and a zero write to status fall on the same edge, status ends set.
- R9: If a match write and an expiry fall on the same edge, the write wins. The expiry is discarded: no status change and no counter snap. The new countdown is measured from the old stored counter.
- R10: Offset 0x00 and every offset outside the map read zero. Writes to unmapped offsets change no register.
- R11: Offset 0x1C holds all 32 written bits and reads them back.
- R12: `irq` equals the status bit read at 0x14 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Countdown step enable, one cycle per timebase tick |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read enable; rd_data is zero when low |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, equal to status |

## Verification
Expiry can land on the same edge as a status-clear write, or on the same edge as a new match write. The bench provokes both collisions. It arms a three-tick countdown with `tick_en` held high, then times the second bus write so that it is sampled on exactly the third edge. A behavioural model in the bench resolves the collision by the stated priorities: expiry beats the clear, and the match write beats the expiry. On every cycle the model is compared against `irq` and the read data, and directed checks confirm that status stays set in the first collision and that no interrupt fires in the second.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam int OFF_MATCH = 'h00;
  localparam int OFF_COUNT = 'h10;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_IEN   = 'h1C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_IEN   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] count_view,
  input  logic          stat_bit,
  input  logic [DW-1:0] ien_val,
  output logic          wr_match,
  output logic          wr_stat,
  output logic          wr_ien,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] A_MATCH = AW'(OFF_MATCH);
  localparam logic [AW-1:0] A_COUNT = AW'(OFF_COUNT);
  localparam logic [AW-1:0] A_STAT  = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_IEN   = AW'(OFF_IEN);

  rd_sel_e sel;

  assign wr_match = wr_en && (addr == A_MATCH);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign wr_ien   = wr_en && (addr == A_IEN);

  always_comb begin
    sel = SEL_NONE;
    if (rd_en) begin
      if (addr == A_COUNT)     sel = SEL_COUNT;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_IEN)  sel = SEL_IEN;
    end
  end

  always_comb begin
    case (sel)
      SEL_COUNT: rd_data = count_view;
      SEL_STAT:  rd_data = {{(DW-1){1'b0}}, stat_bit};
      SEL_IEN:   rd_data = ien_val;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mtimer_countdown.sv
module mtimer_countdown
  import mtimer_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          fire,
  output logic          running,
  output logic [DW-1:0] remain,
  output logic [DW-1:0] count_view
);
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ONE      = DW'(1);

  logic [DW-1:0] match_q;
  logic [DW-1:0] snap_q;
  logic [DW-1:0] remain_q;
  logic          run_q;
  logic [DW-1:0] span;

  // wrap-aware distance from the stored counter to the new match value
  always_comb begin
    if (load_val > snap_q) span = load_val - snap_q;
    else                   span = load_val + (ALL_ONES - snap_q);
  end

  assign fire = run_q && tick_en && (remain_q <= ONE) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      snap_q   <= '0;
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (load) begin
      match_q  <= load_val;
      remain_q <= span;
      run_q    <= 1'b1;
    end else if (fire) begin
      snap_q   <= match_q;
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (run_q && tick_en) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign running    = run_q;
  assign remain     = remain_q;
  assign count_view = match_q - remain_q;
endmodule

// File: rtl/mtimer_flag.sv
module mtimer_flag
  import mtimer_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          wr_stat,
  input  logic          wr_ien,
  input  logic [DW-1:0] wdata,
  output logic          stat_bit,
  output logic [DW-1:0] ien_val
);
  logic          stat_q;
  logic [DW-1:0] ien_q;
  logic          set_req;
  logic          clr_req;

  assign set_req = fire && (ien_q != '0);
  assign clr_req = wr_stat && (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      if (set_req)      stat_q <= 1'b1;
      else if (clr_req) stat_q <= 1'b0;
      if (wr_ien) ien_q <= wdata;
    end
  end

  assign stat_bit = stat_q;
  assign ien_val  = ien_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtimer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic          wr_match, wr_stat, wr_ien;
  logic          fire, running, stat_bit;
  logic [DW-1:0] remain, count_view, ien_val;

  mtimer_decode #(.AW(AW), .DW(DW)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .count_view(count_view), .stat_bit(stat_bit), .ien_val(ien_val),
    .wr_match(wr_match), .wr_stat(wr_stat), .wr_ien(wr_ien),
    .rd_data(rd_data)
  );

  mtimer_countdown #(.DW(DW)) u_cd (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load(wr_match), .load_val(wr_data),
    .fire(fire), .running(running), .remain(remain),
    .count_view(count_view)
  );

  mtimer_flag #(.DW(DW)) u_flag (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .wr_stat(wr_stat), .wr_ien(wr_ien), .wdata(wr_data),
    .stat_bit(stat_bit), .ien_val(ien_val)
  );

  assign irq = stat_bit;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          irq,
  input logic          fire,
  input logic          running,
  input logic [DW-1:0] remain,
  input logic [DW-1:0] ien_val,
  input logic [DW-1:0] count_view
);
  logic wm, ws, mapped;
  assign wm = wr_en && (addr == AW'('h00));
  assign ws = wr_en && (addr == AW'('h14));
  assign mapped = (addr == AW'('h10)) || (addr == AW'('h14)) || (addr == AW'('h1C));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && remain > 1 && !wm) |=> (remain == $past(remain) - 1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wm) |=> $stable(remain));
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!running && count_view == $past(count_view) + $past(remain)));
  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ien_val != '0) |=> irq);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ien_val == '0) |=> $stable(irq));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ws && wr_data == '0 && !fire) |=> !irq);
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ws && wr_data != '0 && !fire) |=> $stable(irq));
  assert_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wm |=> running);
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |-> (rd_data == '0));
endmodule

bind match_timer match_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
  .irq(irq), .fire(fire), .running(running), .remain(remain),
  .ien_val(ien_val), .count_view(count_view)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  match_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference model
  bit [31:0] m_match, m_cnt, m_rem, m_ie;
  bit        m_run, m_stat;

  function automatic bit [31:0] model_read(input bit [7:0] a);
    case (a)
      8'h10:   return m_match - m_rem;
      8'h14:   return {31'b0, m_stat};
      8'h1C:   return m_ie;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit wm, ex;
    longint d;
    if (!rst_n) begin
      m_match = 0; m_cnt = 0; m_rem = 0; m_ie = 0; m_run = 0; m_stat = 0;
    end else begin
      cycles++;
      wm = wr_en && addr == 8'h00;
      ex = m_run && tick_en && m_rem <= 1 && !wm;
      if (ex && m_ie != 0) m_stat = 1;
      else if (wr_en && addr == 8'h14 && wr_data == 0) m_stat = 0;
      if (wr_en && addr == 8'h1C) m_ie = wr_data;
      if (wm) begin
        if (wr_data > m_cnt) d = longint'(wr_data) - longint'(m_cnt);
        else d = (longint'(wr_data) + 64'hFFFF_FFFF - longint'(m_cnt)) % 64'h1_0000_0000;
        m_match = wr_data; m_rem = d[31:0]; m_run = 1;
      end else if (ex) begin
        m_cnt = m_match; m_rem = 0; m_run = 0;
      end else if (m_run && tick_en) m_rem = m_rem - 1;
    end
  end

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R12 irq vs model", {31'b0, irq}, {31'b0, m_stat});
      if (rd_en) begin
        case (addr)
          8'h10:   check("R4 model counter", rd_data, model_read(addr));
          8'h14:   check("R7 model status", rd_data, model_read(addr));
          8'h1C:   check("R11 model ien", rd_data, model_read(addr));
          default: check("R10 model unmapped", rd_data, model_read(addr));
        endcase
      end
    end
  end

  task automatic bus_wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    rd_en = 0; addr = a; wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input bit [7:0] a, input bit [31:0] exp);
    addr = a; rd_en = 1;
    #2;
    check(req, rd_data, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 counter", 8'h10, 0);
    rd_chk("R1 status", 8'h14, 0);
    rd_chk("R1 ien", 8'h1C, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd_chk("R10 match offset reads zero", 8'h00, 0);

    // R11 ien round trip
    bus_wr(8'h1C, 32'hA5A5_0001);
    rd_chk("R11 ien readback", 8'h1C, 32'hA5A5_0001);

    // R4 / R3 : arm 20 from counter 0
    bus_wr(8'h00, 20);
    rd_chk("R4 counter after arm", 8'h10, 0);
    tick_en = 0;
    repeat (4) @(negedge clk);
    rd_chk("R3 counter holds without tick", 8'h10, 0);
    tick_en = 1;
    repeat (5) @(negedge clk);
    rd_chk("R3 counter after 5 ticks", 8'h10, 5);
    repeat (14) @(negedge clk);
    rd_chk("R4 counter at 19", 8'h10, 19);
    check("R6 irq before expiry", {31'b0, irq}, 0);
    @(negedge clk);
    check("R6 irq on expiry", {31'b0, irq}, 1);
    rd_chk("R5 counter snapped", 8'h10, 20);
    repeat (3) @(negedge clk);
    rd_chk("R5 stopped", 8'h10, 20);
    rd_chk("R6 status set", 8'h14, 1);

    // R7 status writes
    bus_wr(8'h14, 7);
    check("R7 nonzero write ignored", {31'b0, irq}, 1);
    bus_wr(8'h14, 0);
    check("R7 zero write clears", {31'b0, irq}, 0);
    rd_chk("R7 status cleared", 8'h14, 0);

    // R2 wrap distance: counter 20, match 10
    bus_wr(8'h00, 10);
    rd_chk("R2 wrapped arm counter", 8'h10, 21);
    // rearm forward: distance 3 from stored 20
    bus_wr(8'h00, 23);
    rd_chk("R2 forward arm counter", 8'h10, 20);
    repeat (3) @(negedge clk);
    check("R6 expiry after 3", {31'b0, irq}, 1);

    // R8 expiry and clear on same edge
    bus_wr(8'h00, 26);
    @(negedge clk);
    bus_wr(8'h14, 0);
    check("R8 status survives clear", {31'b0, irq}, 1);
    rd_chk("R8 counter snapped", 8'h10, 26);

    // R6 disabled interrupt
    bus_wr(8'h14, 0);
    bus_wr(8'h1C, 0);
    bus_wr(8'h00, 28);
    repeat (3) @(negedge clk);
    check("R6 no irq when disabled", {31'b0, irq}, 0);
    rd_chk("R5 counter 28", 8'h10, 28);

    // R9 match write on the expiry edge
    bus_wr(8'h1C, 1);
    bus_wr(8'h00, 31);
    @(negedge clk);
    bus_wr(8'h00, 33);
    check("R9 expiry discarded", {31'b0, irq}, 0);
    rd_chk("R9 measured from old counter", 8'h10, 28);
    repeat (5) @(negedge clk);
    check("R9 new countdown expires", {31'b0, irq}, 1);
    rd_chk("R9 counter 33", 8'h10, 33);

    // R10 unmapped writes and reads
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'h0);
    rd_chk("R10 read 0x08", 8'h08, 0);
    rd_chk("R10 read 0x04", 8'h04, 0);
    rd_chk("R10 counter untouched", 8'h10, 33);
    rd_chk("R10 ien untouched", 8'h1C, 1);
    check("R10 irq untouched", {31'b0, irq}, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule